// File: doc/BRIEF.md
# Rail On/Off Sequencing Controller

This block decides, for one output rail, when the power stage may run and when a ramp should start. Start-up is qualified first: the device must report that its initialization is complete, and the digitized input voltage must have crossed the turn-on threshold. Until both conditions hold, the block pulls a shared open-drain run line low and holds a shared timing clock line low. Every device on those lines therefore starts from the same moment and the same time base.

Once qualified, an on request starts a delay counted in edges of the shared clock, and then a soft-start ramp request is raised. An on request is the run level together with the bus on command, where the command counts only when bus control is enabled. Dropping that request starts a second, separately programmed delay, then a ramp-down request. The power stage stays enabled until the ramp engine reports that the ramp is done. Undervoltage, an external or internal fault, or a silent shared clock kill the stage in the next cycle, with no ramp. Loss of the shared clock is detected with a timeout counted in local cycles.

Top module: `rail_seq_ctrl`

## Requirements
- R1: After reset, `seq_state` is 1 (WAIT_QUALIFY), `stage_en` is 0, and both `run_pull_low` and `sclk_hold` are 1. The state codes are OFF=0, WAIT_QUALIFY=1, ON_DELAY=2, RAMP_UP=3, ON=4, OFF_DELAY=5, RAMP_DOWN=6, FAULT_OFF=7.
- R2: The input-voltage flag is set by `vin_above_on` and cleared by `vin_below_off`. When it is set and `init_done` is high, `run_pull_low` and `sclk_hold` drop to 0 and the state moves from WAIT_QUALIFY to OFF.
- R3: While the block is unqualified, `run_in` has no effect and the state stays WAIT_QUALIFY.
- R4: An on request is `run_in & (bus_on | ~bus_ctrl_en)`. In OFF it enters ON_DELAY. `ramp_up_req` rises one cycle after `on_dly` rising edges of the shared clock have been counted.
- R5: In RAMP_UP, `ramp_up_req` and `stage_en` are high. A `ramp_up_done` pulse moves the state to ON, where `stage_en` stays high and `ramp_up_req` drops.
- R6: With `bus_ctrl_en` low, a low `bus_on` has no effect on a running rail.
- R7: Losing the on request in RAMP_UP or ON enters OFF_DELAY with `stage_en` still high. `ramp_down_req` rises after `off_dly` shared-clock edges.
- R8: In RAMP_DOWN, `stage_en` stays high and a renewed on request is ignored until `ramp_down_done`, which returns the state to OFF with `stage_en` low.
- R9: `vin_below_off` in any of states 2 to 6 sends the state to WAIT_QUALIFY and clears `stage_en` in the next cycle, with no ramp-down request.
- R10: `ext_fault` or `int_fault` in any of states 2 to 6 sends the state to FAULT_OFF and clears `stage_en` in the next cycle.
- R11: If no rising edge of `sclk_in` arrives for `sclk_timeout` local cycles while the state is 2 to 6, the state becomes FAULT_OFF.
- R12: FAULT_OFF is left for OFF only after all faults are clear and `run_in` has been seen low and then high again.
- R13: When undervoltage and a fault arrive in the same cycle, undervoltage wins (WAIT_QUALIFY). When a fault and a bus off command arrive in the same cycle, the fault wins (FAULT_OFF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low reset |
| init_done | input | 1 | Device initialization finished |
| vin_above_on | input | 1 | Input voltage above turn-on threshold |
| vin_below_off | input | 1 | Input voltage below turn-off threshold |
| run_in | input | 1 | Run line above its high threshold |
| sclk_in | input | 1 | Shared timing clock line level |
| ext_fault | input | 1 | External fault input |
| int_fault | input | 1 | Internal fault flag |
| bus_on | input | 1 | Bus on/off command (1 = on) |
| bus_ctrl_en | input | 1 | Configuration allows bus on/off control |
| on_dly | input | DLY_W | Turn-on delay in shared-clock edges |
| off_dly | input | DLY_W | Turn-off delay in shared-clock edges |
| sclk_timeout | input | TO_W | Local cycles without a shared edge before loss |
| ramp_up_done | input | 1 | Soft-start ramp finished |
| ramp_down_done | input | 1 | Ramp-down finished |
| run_pull_low | output | 1 | Pull shared run line low |
| sclk_hold | output | 1 | Hold shared clock line low |
| ramp_up_req | output | 1 | Request soft-start ramp |
| ramp_down_req | output | 1 | Request ramp-down |
| stage_en | output | 1 | Power stage enable |
| seq_state | output | 3 | Current sequencing state code |

## Verification
The controlled turn-off path and the hard-kill path can be triggered in the same cycle, and so can the undervoltage kill and the fault kill. The bench provokes both cases: it lowers `bus_on` with bus control enabled and raises `int_fault` on the same clock edge, and in a separate run it raises `vin_below_off` together with `ext_fault`. The result is judged one cycle later from `seq_state` and `stage_en`. The kill must win over the ramped turn-off with no ramp-down request, and undervoltage must win over the fault.

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl #(
  parameter int DLY_W = 16,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_done,
  input  logic             vin_above_on,
  input  logic             vin_below_off,
  input  logic             run_in,
  input  logic             sclk_in,
  input  logic             ext_fault,
  input  logic             int_fault,
  input  logic             bus_on,
  input  logic             bus_ctrl_en,
  input  logic [DLY_W-1:0] on_dly,
  input  logic [DLY_W-1:0] off_dly,
  input  logic [TO_W-1:0]  sclk_timeout,
  input  logic             ramp_up_done,
  input  logic             ramp_down_done,
  output logic             run_pull_low,
  output logic             sclk_hold,
  output logic             ramp_up_req,
  output logic             ramp_down_req,
  output logic             stage_en,
  output logic [2:0]       seq_state
);

  localparam logic [2:0] S_OFF = 3'd0, S_WAIT = 3'd1, S_OND = 3'd2, S_UP = 3'd3,
                         S_ON = 3'd4, S_OFFD = 3'd5, S_DN = 3'd6, S_FLT = 3'd7;

  logic [2:0]       st, nst;
  logic             vin_ok, qualified, on_req, fault, active, clk_lost;
  logic             s1, s2, s3, tick, run_low_seen;
  logic [DLY_W-1:0] dcnt;
  logic [TO_W-1:0]  lcnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, s3} <= '0;
    else        {s1, s2, s3} <= {sclk_in, s1, s2};

  assign tick = s2 & ~s3;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            lcnt <= '0;
    else if (tick)         lcnt <= '0;
    else if (lcnt != '1)   lcnt <= lcnt + 1'b1;

  assign clk_lost = (lcnt >= sclk_timeout);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             vin_ok <= 1'b0;
    else if (vin_below_off) vin_ok <= 1'b0;
    else if (vin_above_on)  vin_ok <= 1'b1;

  assign qualified = init_done & vin_ok;
  assign on_req    = run_in & (bus_on | ~bus_ctrl_en);
  assign fault     = ext_fault | int_fault | clk_lost;
  assign active    = (st >= S_OND) && (st <= S_DN);

  always_comb begin
    nst = st;
    case (st)
      S_WAIT: if (qualified) nst = S_OFF;
      S_OFF:  if (!qualified) nst = S_WAIT;
              else if (on_req) nst = S_OND;
      S_OND:  if (!on_req) nst = S_OFF;
              else if (dcnt == on_dly) nst = S_UP;
      S_UP:   if (!on_req) nst = S_OFFD;
              else if (ramp_up_done) nst = S_ON;
      S_ON:   if (!on_req) nst = S_OFFD;
      S_OFFD: if (dcnt == off_dly) nst = S_DN;
      S_DN:   if (ramp_down_done) nst = S_OFF;
      S_FLT:  if (!fault && run_low_seen && run_in) nst = S_OFF;
      default: nst = S_WAIT;
    endcase
    if (active) begin
      if (vin_below_off) nst = S_WAIT;
      else if (fault)    nst = S_FLT;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= S_WAIT;
    else        st <= nst;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                dcnt <= '0;
    else if (st != nst)                        dcnt <= '0;
    else if (tick && (st == S_OND || st == S_OFFD)) dcnt <= dcnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            run_low_seen <= 1'b0;
    else if (st != S_FLT)  run_low_seen <= 1'b0;
    else if (!run_in)      run_low_seen <= 1'b1;

  assign run_pull_low  = ~qualified;
  assign sclk_hold     = ~qualified;
  assign ramp_up_req   = (st == S_UP);
  assign ramp_down_req = (st == S_DN);
  assign stage_en      = (st == S_UP) || (st == S_ON) || (st == S_OFFD) || (st == S_DN);
  assign seq_state     = st;

endmodule

// File: rtl/rail_seq_ctrl_chk.sv
module rail_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       init_done,
  input logic       vin_below_off,
  input logic       ext_fault,
  input logic       int_fault,
  input logic       ramp_down_done,
  input logic       clk_lost,
  input logic       run_pull_low,
  input logic       ramp_up_req,
  input logic       ramp_down_req,
  input logic       stage_en,
  input logic [2:0] seq_state
);
  logic act;
  assign act = (seq_state >= 3'd2) && (seq_state <= 3'd6);

  p_uninit_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> run_pull_low);

  p_uv_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vin_below_off |=> run_pull_low);

  p_uv_kill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (act && vin_below_off) |=> (seq_state == 3'd1 && !stage_en && !ramp_down_req));

  p_fault_kill_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !vin_below_off && (ext_fault || int_fault)) |=> (seq_state == 3'd7 && !stage_en));

  p_ramp_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ramp_up_req, ramp_down_req}));

  p_up_stage_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_up_req |-> stage_en);

  p_down_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 3'd6 && !ramp_down_done && !vin_below_off && !ext_fault && !int_fault && !clk_lost)
      |=> (seq_state == 3'd6 && stage_en));
endmodule

bind rail_seq_ctrl rail_seq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .init_done(init_done), .vin_below_off(vin_below_off),
  .ext_fault(ext_fault), .int_fault(int_fault), .ramp_down_done(ramp_down_done),
  .clk_lost(clk_lost), .run_pull_low(run_pull_low), .ramp_up_req(ramp_up_req),
  .ramp_down_req(ramp_down_req), .stage_en(stage_en), .seq_state(seq_state)
);

// File: tb/sim_rail_seq_ctrl.sv
`timescale 1ns/1ps
module sim_rail_seq_ctrl;
  logic clk = 0, rst_n = 0;
  logic init_done = 0, vin_above_on = 0, vin_below_off = 0, run_in = 0, sclk_in = 0;
  logic ext_fault = 0, int_fault = 0, bus_on = 0, bus_ctrl_en = 0;
  logic [15:0] on_dly = 16'd5, off_dly = 16'd3, sclk_timeout = 16'd100;
  logic ramp_up_done = 0, ramp_down_done = 0;
  logic run_pull_low, sclk_hold, ramp_up_req, ramp_down_req, stage_en;
  logic [2:0] seq_state;
  logic sclk_run = 1;
  int total = 0, bad = 0;

  rail_seq_ctrl u0 (.*);

  always #2.5 clk = ~clk;

  initial forever begin
    if (sclk_run) begin #50; sclk_in = ~sclk_in; end
    else #5;
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic go_on();
    ext_fault = 0; int_fault = 0; vin_below_off = 0; ramp_up_done = 0;
    bus_ctrl_en = 1; bus_on = 1; run_in = 0; on_dly = 0; off_dly = 0;
    for (int i = 0; i < 300; i++) begin
      if (seq_state == 3'd0 || seq_state == 3'd1 || seq_state == 3'd7) break;
      ramp_down_done = ramp_down_req;
      cyc(1);
    end
    ramp_down_done = 0;
    cyc(3);
    run_in = 1;
    for (int i = 0; i < 300; i++) begin
      if (ramp_up_req) break;
      cyc(1);
    end
    ramp_up_done = 1; cyc(1); ramp_up_done = 0; cyc(1);
    chk(seq_state == 3'd4, "R5 go_on reaches ON", seq_state, 4);
  endtask

  task automatic t_reset();
    cyc(2);
    chk(seq_state == 3'd1, "R1 state", seq_state, 1);
    chk(stage_en == 0, "R1 stage_en", stage_en, 0);
    chk(run_pull_low && sclk_hold, "R1 line holds", {run_pull_low, sclk_hold}, 3);
  endtask

  task automatic t_qualify();
    vin_above_on = 1; run_in = 1; cyc(10);
    chk(seq_state == 3'd1, "R3 run ignored unqualified", seq_state, 1);
    chk(run_pull_low == 1, "R3 run line held", run_pull_low, 1);
    run_in = 0; init_done = 1; cyc(2);
    chk(!run_pull_low && !sclk_hold, "R2 lines released", {run_pull_low, sclk_hold}, 0);
    cyc(1);
    chk(seq_state == 3'd0, "R2 state OFF", seq_state, 0);
  endtask

  task automatic t_turn_on();
    on_dly = 5; run_in = 1; cyc(2);
    chk(seq_state == 3'd2, "R4 ON_DELAY", seq_state, 2);
    cyc(60);
    chk(ramp_up_req == 0, "R4 early", ramp_up_req, 0);
    cyc(80);
    chk(ramp_up_req == 1, "R4 ramp request", ramp_up_req, 1);
    chk(stage_en == 1, "R5 stage during ramp", stage_en, 1);
    ramp_up_done = 1; cyc(1); ramp_up_done = 0;
    chk(seq_state == 3'd4 && !ramp_up_req, "R5 ON", seq_state, 4);
  endtask

  task automatic t_bus_ignored();
    bus_ctrl_en = 0; bus_on = 0; cyc(20);
    chk(seq_state == 3'd4 && stage_en, "R6 bus off ignored", seq_state, 4);
  endtask

  task automatic t_bus_off();
    off_dly = 3; bus_ctrl_en = 1; bus_on = 0; cyc(2);
    chk(seq_state == 3'd5 && stage_en, "R7 OFF_DELAY stage held", seq_state, 5);
    cyc(30);
    chk(ramp_down_req == 0, "R7 early", ramp_down_req, 0);
    cyc(100);
    chk(ramp_down_req == 1, "R7 ramp down", ramp_down_req, 1);
    bus_on = 1; cyc(10);
    chk(seq_state == 3'd6 && stage_en, "R8 mode held", seq_state, 6);
    ramp_down_done = 1; cyc(1); ramp_down_done = 0;
    chk(seq_state == 3'd0 && !stage_en, "R8 OFF after done", seq_state, 0);
  endtask

  task automatic t_uv();
    go_on();
    vin_below_off = 1; cyc(1); vin_below_off = 0;
    chk(seq_state == 3'd1 && !stage_en, "R9 UV kill", seq_state, 1);
    chk(ramp_down_req == 0, "R9 no ramp", ramp_down_req, 0);
  endtask

  task automatic t_ext_fault();
    go_on();
    ext_fault = 1; cyc(1);
    chk(seq_state == 3'd7 && !stage_en, "R10 ext fault kill", seq_state, 7);
    ext_fault = 0; cyc(10);
    chk(seq_state == 3'd7, "R12 needs run toggle", seq_state, 7);
    run_in = 0; cyc(2); run_in = 1; cyc(2);
    chk(seq_state != 3'd7, "R12 exit", seq_state, 0);
  endtask

  task automatic t_int_fault();
    go_on();
    int_fault = 1; cyc(1);
    chk(seq_state == 3'd7 && !stage_en, "R10 int fault kill", seq_state, 7);
    run_in = 0; cyc(2); run_in = 1; cyc(2);
    chk(seq_state == 3'd7, "R12 fault still present", seq_state, 7);
    int_fault = 0;
  endtask

  task automatic t_clk_loss();
    go_on();
    sclk_run = 0; cyc(60);
    chk(seq_state == 3'd4, "R11 before timeout", seq_state, 4);
    cyc(70);
    chk(seq_state == 3'd7 && !stage_en, "R11 clock loss", seq_state, 7);
    sclk_run = 1; cyc(30);
  endtask

  task automatic t_same_cycle();
    go_on();
    vin_below_off = 1; ext_fault = 1; cyc(1); vin_below_off = 0; ext_fault = 0;
    chk(seq_state == 3'd1, "R13 UV beats fault", seq_state, 1);
    go_on();
    bus_on = 0; int_fault = 1; cyc(1);
    chk(seq_state == 3'd7 && !stage_en, "R13 fault beats bus off", seq_state, 7);
    chk(ramp_down_req == 0, "R13 no ramp", ramp_down_req, 0);
    int_fault = 0;
  endtask

  initial begin
    #(5 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1;
    t_reset();
    t_qualify();
    t_turn_on();
    t_bus_ignored();
    t_bus_off();
    t_uv();
    t_ext_fault();
    t_int_fault();
    t_clk_loss();
    t_same_cycle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule